// File: doc/BRIEF.md
# Nametable Mirroring Address Mapper

This block sits on the video-memory side of a tile-based picture processor and resolves every access to the 4 KB nametable window onto two physical 1 KB RAM banks. The window is seen by software as four logical 1 KB screens. Only two banks of storage exist, so pairs of logical screens alias onto the same bytes. A 2-bit fold mode, normally driven by the cartridge's banking logic, chooses how the screens pair up. Two modes put every screen on one bank. The other two pair the screens side by side or one above the other.

The requester presents an address with a read strobe or a write strobe, plus write data and the fold mode. Writes are committed at the clock edge. Reads are synchronous: the byte appears on the output one clock after the read strobe and stays there until the next read. Bank selection is a pure function of the fold mode and two address bits. Changing the mode therefore repoints later accesses at once and leaves the stored contents untouched.

Top module: `nt_fold_mapper`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, `rd_data` is driven to zero. It stays zero after reset until the first read.
- R2: A read strobe at one rising edge places the addressed byte on `rd_data` after that edge. `rd_data` holds its value on every cycle with no read strobe.
- R3: Address bits 9:0 select the byte inside the chosen bank. Address bits above bit 11 have no effect on which byte is reached.
- R4: With `fold_mode` = 0 (single-screen low), every access goes to bank A.
- R5: With `fold_mode` = 1 (single-screen high), every access goes to bank B.
- R6: With `fold_mode` = 2 (vertical pairing), address bit 10 chooses the bank: 0 selects A and 1 selects B.
- R7: With `fold_mode` = 3 (horizontal pairing), address bit 11 chooses the bank: 0 selects A and 1 selects B.
- R8: Reads and writes use the same bank selection. A write changes exactly one physical byte, and every aliased address reads back that value.
- R9: A change of `fold_mode` applies from the next access and clears neither bank.
- R10: A read and a write to the same byte in the same cycle return the byte's contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (14) | Video address; only bits 11:0 are decoded |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (8) | Byte to write |
| fold_mode | input | 2 | 0 single A, 1 single B, 2 vertical, 3 horizontal |
| rd_data | output | DATA_W (8) | Registered read data |

## Verification
The bench writes markers through one logical screen and reads them back through each alias under every fold mode. A decoder that picked the wrong address bit would swap the vertical and horizontal results. A single-screen mode that still decoded the address would return the other bank's marker. Switching modes between writes and reads without touching the data shows whether a mode change loses storage. Other cases cover reads with the top address bits set, which a decoder using too many bits would misroute; idle cycles, which an unheld output would lose; and a same-cycle read and write, which write-first RAM would answer with the new byte.

// File: rtl/nt_fold_pkg.sv
package nt_fold_pkg;
  typedef enum logic [1:0] {
    FOLD_ONE_A = 2'd0,
    FOLD_ONE_B = 2'd1,
    FOLD_VERT  = 2'd2,
    FOLD_HORZ  = 2'd3
  } fold_mode_e;
endpackage

// File: rtl/nt_bank_sel.sv
module nt_bank_sel
  import nt_fold_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       col_bit,
  input  logic       row_bit,
  output logic       pick_b
);
  always_comb begin
    unique case (fold_mode_e'(mode))
      FOLD_ONE_A: pick_b = 1'b0;
      FOLD_ONE_B: pick_b = 1'b1;
      FOLD_VERT:  pick_b = col_bit;
      FOLD_HORZ:  pick_b = row_bit;
      default:    pick_b = 1'b0;
    endcase
  end
endmodule

// File: rtl/nt_bank_ram.sv
module nt_bank_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              re,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  // Read-first output register with synchronous reset
  always_ff @(posedge clk) begin
    if (rst)            rdata <= '0;
    else if (en && re)  rdata <= mem[addr];
  end
endmodule

// File: rtl/nt_fold_mapper.sv
module nt_fold_mapper #(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 14,
  parameter int BANK_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        fold_mode,
  output logic [DATA_W-1:0] rd_data
);
  localparam int WIN_AW  = BANK_AW + 2;
  localparam int N_BANKS = 2;

  logic              pick_b;
  logic              pick_q;
  logic              access;
  logic [N_BANKS-1:0] bank_en;
  logic [DATA_W-1:0] bank_q [N_BANKS];
  logic              unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:WIN_AW];
  assign access    = rd_en | wr_en;

  nt_bank_sel sel_i (
    .mode    (fold_mode),
    .col_bit (addr[BANK_AW]),
    .row_bit (addr[BANK_AW+1]),
    .pick_b  (pick_b)
  );

  assign bank_en[0] = access & ~pick_b;
  assign bank_en[1] = access &  pick_b;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    nt_bank_ram #(.DATA_W(DATA_W), .AW(BANK_AW)) ram_i (
      .clk   (clk),
      .rst   (rst),
      .en    (bank_en[b]),
      .re    (rd_en),
      .we    (wr_en),
      .addr  (addr[BANK_AW-1:0]),
      .wdata (wr_data),
      .rdata (bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        pick_q <= 1'b0;
    else if (rd_en) pick_q <= pick_b;
  end

  assign rd_data = pick_q ? bank_q[1] : bank_q[0];

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  // R4
  single_low_chk: assert property (@(posedge clk) disable iff (rst)
    (fold_mode == 2'd0 && access) |-> (bank_en == 2'b01));

  // R5
  single_high_chk: assert property (@(posedge clk) disable iff (rst)
    (fold_mode == 2'd1 && access) |-> (bank_en == 2'b10));

  // R6
  vert_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (fold_mode == 2'd2 && access) |-> (bank_en[1] == addr[BANK_AW]));

  // R7
  horz_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (fold_mode == 2'd3 && access) |-> (bank_en[1] == addr[BANK_AW+1]));

  // R8
  one_bank_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $onehot(bank_en));
endmodule

// File: tb/nt_fold_mapper_tb_top.sv
module nt_fold_mapper_tb_top;
  localparam int DW = 8;
  localparam int AW = 14;
  localparam int NV = 22;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_RD = 2'd2;

  // {op, mode, addr, data, expected}
  localparam logic [33:0] VEC [NV] = '{
    {OP_WR, 2'd3, 14'h2000, 8'h11, 8'h00},
    {OP_WR, 2'd3, 14'h2800, 8'h22, 8'h00},
    {OP_RD, 2'd3, 14'h2400, 8'h00, 8'h11}, // R7 A alias
    {OP_RD, 2'd3, 14'h2C00, 8'h00, 8'h22}, // R7 B alias
    {OP_RD, 2'd3, 14'h3800, 8'h00, 8'h22}, // R3 top bits ignored
    {OP_RD, 2'd2, 14'h2000, 8'h00, 8'h11}, // R9/R6
    {OP_RD, 2'd2, 14'h2400, 8'h00, 8'h22}, // R6
    {OP_RD, 2'd2, 14'h2800, 8'h00, 8'h11}, // R6
    {OP_RD, 2'd2, 14'h2C00, 8'h00, 8'h22}, // R6
    {OP_RD, 2'd0, 14'h2C00, 8'h00, 8'h11}, // R4
    {OP_WR, 2'd0, 14'h2FFF, 8'h33, 8'h00},
    {OP_RD, 2'd0, 14'h23FF, 8'h00, 8'h33}, // R4/R8
    {OP_RD, 2'd1, 14'h2000, 8'h00, 8'h22}, // R5
    {OP_WR, 2'd1, 14'h2001, 8'h44, 8'h00},
    {OP_RD, 2'd1, 14'h2801, 8'h00, 8'h44}, // R5/R8
    {OP_RD, 2'd2, 14'h2401, 8'h00, 8'h44}, // R6/R8
    {OP_RD, 2'd2, 14'h2BFF, 8'h00, 8'h33}, // R6/R3
    {OP_WR, 2'd3, 14'h2155, 8'h55, 8'h00},
    {OP_RD, 2'd3, 14'h2555, 8'h00, 8'h55}, // R3/R8
    {OP_RD, 2'd0, 14'h3D55, 8'h00, 8'h55}, // R3/R4
    {OP_RD, 2'd1, 14'h2C00, 8'h00, 8'h22}, // R9
    {OP_RD, 2'd3, 14'h2000, 8'h00, 8'h11}  // R9
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    fold_mode = 2'd0;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  nt_fold_mapper dut_i (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .fold_mode(fold_mode), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [DW-1:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] m, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
    @(negedge clk);
    fold_mode = m; addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] m, input logic [AW-1:0] a);
    @(negedge clk);
    fold_mode = m; addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][33:32] == OP_WR) begin
        do_write(VEC[i][31:30], VEC[i][29:16], VEC[i][15:8]);
      end else begin
        do_read(VEC[i][31:30], VEC[i][29:16]);
        check($sformatf("R2/R4-R9 vector %0d", i), VEC[i][7:0]);
      end
    end

    // R2: output holds across idle cycles and strobe-free address changes
    do_read(2'd3, 14'h2800);
    check("R2 read", 8'h22);
    addr = 14'h2000;
    fold_mode = 2'd0;
    repeat (4) @(negedge clk);
    check("R2 hold", 8'h22);

    // R10: read and write to the same byte in one cycle
    @(negedge clk);
    fold_mode = 2'd3; addr = 14'h2000; wr_data = 8'h99;
    rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R10 read-first", 8'h11);
    do_read(2'd2, 14'h2800);
    check("R10/R8 new byte", 8'h99);

    // R1: reset in mid-run clears the output
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", 8'h00);
    rst = 1'b0;
    do_read(2'd1, 14'h2001);
    check("R1/R9 storage kept over reset", 8'h44);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule